// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command nodes held in system memory and hands the payload of each node, one word at a time, to a downstream command consumer. A node is one header word followed by zero or more payload words at the next consecutive word addresses. The header carries the payload length and the pointer to the following node. A pulse on `start` with a start address launches a walk. The block then reads headers and payload through a single-outstanding memory read port, which may take any number of cycles to answer. It streams the payload out under valid/ready flow control.

The chain ends when the address about to be visited has bit 23 set, so no null pointer is needed. A node with no payload only moves the walk on to the next pointer. For each visited node the block adds a fixed estimate of the processing cost to a running total. A cap on the number of visited nodes stops a walk that keeps going round a circular chain. When the cap is hit, the walk is abandoned and an error flag is raised. The block never writes to memory.

Top module: `list_dma_walker`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_req` and `pl_valid` are 0 and `cost` is 0.
- R2: A header word holds the payload length in bits 31:24 and the next node address in bits 23:0. The length words that follow the header at consecutive word addresses (byte address +4, +8, ...) are forwarded on `pl_data` in address order.
- R3: `start_addr` is reduced to its low 24 bits before anything else. The walk ends, with a one-cycle `done` pulse and `busy` falling in the same cycle, as soon as the address about to be visited has bit 23 set. If the start address itself qualifies, no memory read is issued.
- R4: Addresses are byte addresses in a 2 MB space. `mem_addr` is the word index, address bits 20:2, and address bits 22:21 are ignored.
- R5: A node whose length field is 0 forwards no word, and the walk continues at its next pointer.
- R6: `cost` is the sum, over visited nodes, of 10, plus 5 + length when the length is non-zero. It holds its value after `done` until the next accepted start.
- R7: Once NODE_LIMIT nodes have been visited without reaching an end address, the walk stops without further reads, and `done` pulses with `err` set. `err` stays set until the next accepted start and is 0 after a normal end.
- R8: While `pl_valid` is high and `pl_ready` is low, `pl_valid` and `pl_data` hold. No memory read is requested while a payload word is waiting. The next header is fetched only after the last payload word of a node is accepted.
- R9: `start` has no effect while `busy` is high.
- R10: At most one memory read is outstanding. After a one-cycle `mem_req`, no new request is made until `mem_rvalid` returns the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 32 | Address of the first node (low 24 bits used) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when a walk finishes |
| err | output | 1 | Last walk was stopped by the node cap |
| cost | output | COST_W | Accumulated cost estimate of the last walk |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | MEM_AW-2 | Word index of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| pl_valid | output | 1 | Payload word available |
| pl_data | output | 32 | Payload word |
| pl_ready | input | 1 | Downstream accepts the payload word |

## Verification
The hardest situation to reach is the node cap. It needs a chain that never ends, and with the default cap it would take thousands of nodes. The bench therefore builds the block with a cap of 6 and places a two-node cycle in its memory model, so the abort path, the error flag and the partial cost total all appear within a few dozen cycles. Every chain, including one whose link has pointer bits above bit 20 set and one whose start address carries junk in bits 31:24, is run under each combination of three memory latencies and three downstream ready patterns. This brings stalls onto the last payload word of a node, where the next header fetch must wait.

// File: rtl/list_dma_walker.sv
module list_dma_walker #(
  parameter int MEM_AW     = 21,
  parameter int NODE_LIMIT = 8192,
  parameter int COST_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [COST_W-1:0] cost,
  output logic              mem_req,
  output logic [MEM_AW-3:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              pl_valid,
  output logic [31:0]       pl_data,
  input  logic              pl_ready
);
  localparam int PTR_W = 24;
  localparam int CNT_W = 8;
  localparam int NCW   = $clog2(NODE_LIMIT + 1);
  localparam logic [NCW-1:0] NCAP = NCW'(NODE_LIMIT);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_HWAIT, S_PREQ, S_PWAIT, S_POUT} state_t;

  state_t           state;
  logic [PTR_W-1:0] cur, nxt, ptr;
  logic [CNT_W-1:0] left;
  logic [NCW-1:0]   nodes;

  wire              at_end   = cur[PTR_W-1];
  wire              at_cap   = (nodes == NCAP);
  wire [CNT_W-1:0]  hdr_len  = mem_rdata[31:24];
  wire [PTR_W-1:0]  hdr_next = mem_rdata[PTR_W-1:0];
  wire [COST_W-1:0] node_cost = (hdr_len == '0) ? COST_W'(10) : COST_W'(15) + COST_W'(hdr_len);
  wire [PTR_W-1:0]  rd_addr  = (state == S_HDR) ? cur : ptr;

  assign mem_req  = ((state == S_HDR) && !at_end && !at_cap) || (state == S_PREQ);
  assign mem_addr = rd_addr[MEM_AW-1:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur      <= '0;
      nxt      <= '0;
      ptr      <= '0;
      left     <= '0;
      nodes    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      cost     <= '0;
      pl_valid <= 1'b0;
      pl_data  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cur   <= start_addr[PTR_W-1:0];
          cost  <= '0;
          nodes <= '0;
          err   <= 1'b0;
          busy  <= 1'b1;
          state <= S_HDR;
        end
        S_HDR: begin
          if (at_end) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (at_cap) begin
            err   <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            state <= S_HWAIT;
          end
        end
        S_HWAIT: if (mem_rvalid) begin
          cost  <= cost + node_cost;
          nodes <= nodes + 1'b1;
          left  <= hdr_len;
          nxt   <= hdr_next;
          ptr   <= cur + PTR_W'(4);
          if (hdr_len == '0) begin
            cur   <= hdr_next;
            state <= S_HDR;
          end else begin
            state <= S_PREQ;
          end
        end
        S_PREQ: state <= S_PWAIT;
        S_PWAIT: if (mem_rvalid) begin
          pl_data  <= mem_rdata;
          pl_valid <= 1'b1;
          state    <= S_POUT;
        end
        S_POUT: if (pl_ready) begin
          pl_valid <= 1'b0;
          ptr      <= ptr + PTR_W'(4);
          left     <= left - 1'b1;
          if (left == CNT_W'(1)) begin
            cur   <= nxt;
            state <= S_HDR;
          end else begin
            state <= S_PREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/list_dma_walker_chk.sv
module list_dma_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mem_req,
  input logic        mem_rvalid,
  input logic        pl_valid,
  input logic [31:0] pl_data,
  input logic        pl_ready
);
  // R10
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R8
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && !pl_ready) |=> (pl_valid && $stable(pl_data)));

  // R8
  no_fetch_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid |-> !mem_req);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind list_dma_walker list_dma_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .mem_rvalid(mem_rvalid), .pl_valid(pl_valid),
  .pl_data(pl_data), .pl_ready(pl_ready)
);

// File: tb/sim_list_dma_walker.sv
`timescale 1ns/1ps
module sim_list_dma_walker;
  localparam int LIMIT = 6;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] start_addr = 0;
  logic        busy, done, err;
  logic [31:0] cost;
  logic        mem_req;
  logic [18:0] mem_addr;
  logic        mem_rvalid = 0;
  logic [31:0] mem_rdata = 0;
  logic        pl_valid;
  logic [31:0] pl_data;
  logic        pl_ready = 0;

  always #10 clk = ~clk;

  list_dma_walker #(.MEM_AW(21), .NODE_LIMIT(LIMIT), .COST_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .err(err), .cost(cost),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .pl_valid(pl_valid), .pl_data(pl_data),
    .pl_ready(pl_ready)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:255];
  int lat = 1, rmode = 0, reads = 0;
  int got_n = 0, stall_bad = 0, fetch_bad = 0;
  logic [31:0] got [0:255];
  int cyc = 0;

  // memory responder
  initial begin
    logic pend; int wc; logic [7:0] pa;
    pend = 0; wc = 0; pa = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (pend) begin
        if (wc == 0) begin mem_rvalid = 1; mem_rdata = mem[pa]; pend = 0; end
        else wc--;
      end else if (mem_req) begin
        pend = 1; pa = mem_addr[7:0]; wc = lat - 1; reads++;
      end
    end
  end

  // payload sink
  initial begin
    logic prev_stall; logic [31:0] prev_data;
    prev_stall = 0; prev_data = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (prev_stall && (!pl_valid || pl_data !== prev_data)) stall_bad++;
      if (pl_valid && mem_req) fetch_bad++;
      pl_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 2 == 0) : (cyc % 3 == 0);
      if (pl_valid && pl_ready) begin got[got_n[7:0]] = pl_data; got_n++; end
      prev_stall = pl_valid && !pl_ready;
      prev_data  = pl_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_walk(input logic [31:0] sa, input bit poke_busy);
    logic [23:0] a; int nodes; logic [31:0] ecost; bit eerr; int en, ereads;
    logic [31:0] ew [0:255]; int to; bit seen; logic [31:0] w1;
    // expected result from the requirements
    a = sa[23:0]; nodes = 0; ecost = 0; eerr = 0; en = 0; ereads = 0;
    while (!a[23]) begin
      logic [31:0] h; int n;
      if (nodes == LIMIT) begin eerr = 1; break; end
      h = mem[a[9:2]]; n = h[31:24]; ereads++;
      ecost += 10 + ((n != 0) ? 5 + n : 0);
      for (int i = 1; i <= n; i++) begin
        ew[en[7:0]] = mem[8'(a[9:2] + 8'(i))]; en++; ereads++;
      end
      a = h[23:0]; nodes++;
    end
    got_n = 0; reads = 0; stall_bad = 0; fetch_bad = 0;
    @(negedge clk); start = 1; start_addr = sa;
    @(negedge clk); start = 0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      start = 1; start_addr = 32'h0000_0040;
      @(negedge clk); start = 0;
    end
    seen = 0; to = 0;
    while (!seen && to < 5000) begin
      if (done) seen = 1; else begin @(negedge clk); to++; end
    end
    chk(seen, "R3 done", {31'd0, seen}, 1);
    if (!seen) return;
    chk(!busy, "R3 busy low at done", {31'd0, busy}, 0);
    chk(cost == ecost, "R6 cost", cost, ecost);
    chk(err == eerr, "R7 err", {31'd0, err}, {31'd0, eerr});
    chk(got_n == en, poke_busy ? "R9 word count" : "R2 word count", got_n, en);
    w1 = 0;
    for (int i = 0; i < en && i < got_n; i++) if (got[i] !== ew[i]) w1++;
    chk(w1 == 0, "R2 R4 R5 payload order", w1, 0);
    chk(reads == ereads, "R3 R7 R10 read count", reads, ereads);
    chk(stall_bad == 0 && fetch_bad == 0, "R8 backpressure", stall_bad + fetch_bad, 0);
    @(negedge clk);
    chk(!done && cost == ecost && err == eerr, "R6 R7 hold after done", cost, ecost);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
    // chain A at byte 0x40: len 3 -> 0x80 ; len 0 -> 0x200090 (bit 21 ignored) ; len 2 -> end
    mem[8'h10] = 32'h0300_0080;
    mem[8'h11] = 32'hA000_0001; mem[8'h12] = 32'hA000_0002; mem[8'h13] = 32'hA000_0003;
    mem[8'h20] = 32'h0020_0090;
    mem[8'h24] = 32'h0280_0000;
    mem[8'h25] = 32'hB000_0001; mem[8'h26] = 32'hB000_0002;
    // circular chain at 0x100 <-> 0x110
    mem[8'h40] = 32'h0100_0110; mem[8'h41] = 32'hC000_0001;
    mem[8'h44] = 32'h0000_0100;
    // single empty node at 0x200 pointing to end
    mem[8'h80] = 32'h00FF_FFFF;
    // length-7 node at 0x300 -> end via bit 23 with other bits set
    mem[8'hC0] = 32'h07C0_0004;
    for (int i = 1; i <= 7; i++) mem[8'hC0 + i] = 32'hE000_0000 + i;

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(!busy && !done && !err && !mem_req && !pl_valid && cost == 0, "R1 reset state",
        {busy, done, err, mem_req, pl_valid}, 0);

    for (int l = 1; l <= 3; l++) begin
      for (int r = 0; r < 3; r++) begin
        lat = l; rmode = r;
        run_walk(32'h0000_0040, 0);   // R2 R4 R5 R6
        run_walk(32'hFF80_0000, 0);   // R3 immediate end, no reads
        run_walk(32'h7F00_0040, 0);   // R3 upper bits masked
        run_walk(32'h0000_0100, 0);   // R7 node cap
        run_walk(32'h0000_0200, 0);   // R5 empty node only
        run_walk(32'h0000_0300, 0);   // R2 long payload
        run_walk(32'h0000_0300, 1);   // R9 start while busy
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule